// File: doc/BRIEF.md
# I3C Target In-Band Interrupt Requester

This block lets an I3C target ask the active controller for attention without a separate interrupt wire. When it is given a request, it waits for a START that begins a fresh transaction. It then drives its own 7-bit dynamic address and a read bit into the arbitrated header. SDA is driven open-drain style: an output enable pulls the line low, and a released line reads high. Each bit it releases is compared with the line sampled on the SCL rising edge. If another target pulls the line low, this block has lost arbitration. It backs off at once and stays off the line until the bus has been idle for a programmable number of clock cycles.

When the block wins, it samples the controller's acknowledge bit. If the request was marked as carrying a payload, it then shifts out one data byte, MSB first. A NACK ends the attempt, and the request stays armed for the next START. If the bus has sat idle long enough and no START has appeared, the block creates its own START. It pulls SDA low and waits for the controller to take SCL low.

Status is reported as single-cycle pulses: done, lost and nacked. A busy output shows that a request is pending.

Top module: `ibi_requester`

## Requirements
- R1: After reset, SDA is released, busy is low and no status pulse is given.
- R2: After a request pulse, busy is high. At the next START, the block drives its dynamic address MSB first, then RnW = 1, as one 8-bit header. It drives a bit during SCL low and holds it through SCL high.
- R3: Arbitration is a wired AND, so the lower address wins. When the block releases SDA but samples 0, it gives one lost pulse and releases SDA for the rest of that frame. The header seen on the wire is that of the lower address.
- R4: On an ACK (SDA low in the ninth bit), a request without payload gives a done pulse. A request with payload first drives its 8-bit payload MSB first and gives done at the next SCL falling edge. After done, busy is low.
- R5: A NACK (SDA high in the ninth bit) gives one nacked pulse and keeps busy high. The block then joins the header after the next START.
- R6: After a loss, the block does not drive SDA after any START until SCL and SDA have both been high for the programmed number of idle cycles.
- R7: While a request is armed and the idle window expires with no START, the block pulls SDA low. It sends its header once the controller drives SCL low.
- R8: A repeated START (one without a STOP or an idle window since the last START) is never joined. A request that arrives in the middle of a transaction leaves that transaction's headers untouched.
- R9: Each attempt ends with at most one of done, lost or nacked, never two in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (wired AND of all drivers) |
| dyn_addr_i | input | ADDR_W (7) | Own dynamic address, used in the header |
| avail_cycles_i | input | CNT_W (8) | Number of cycles with both lines high that counts as an idle bus |
| req_i | input | 1 | Single-cycle pulse that arms an interrupt request |
| payload_i | input | DATA_W (8) | Payload byte, captured with the request |
| payload_en_i | input | 1 | When high, the request carries the payload byte |
| sda_oe_o | output | 1 | When high, pull SDA low; otherwise SDA is released |
| busy_o | output | 1 | A request is pending or in progress |
| done_o | output | 1 | Pulse: request acknowledged and completed |
| lost_o | output | 1 | Pulse: arbitration lost |
| nacked_o | output | 1 | Pulse: controller refused the header |

## Verification
The bench builds the block with its default sizes: a 7-bit address, an 8-bit payload, an 8-bit idle counter and a two-stage input synchronizer. It runs with an idle window of 40 cycles. It sweeps an 8 by 8 grid of own and competing addresses, so both win and loss orders appear, and the first differing bit falls at several header positions. Payload is switched on and off across the grid. Separate passes cover a NACK followed by a retry, a request that arrives mid-transaction before a repeated START, and the self-generated START after a loss.

// File: rtl/ibi_pkg.sv
package ibi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARMED,
        ST_HDR_WAIT,
        ST_SELF_START,
        ST_ADDR,
        ST_ACK,
        ST_DATA,
        ST_TAIL,
        ST_BACKOFF
    } ibi_state_e;

endpackage

// File: rtl/ibi_bus_mon.sv
module ibi_bus_mon #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [CNT_W-1:0] avail_cycles_i,
    output logic             sda_o,
    output logic             scl_rise_o,
    output logic             scl_fall_o,
    output logic             start_o,
    output logic             stop_o,
    output logic             avail_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_p;
        logic                   sda_p;
        logic [CNT_W-1:0]       cnt;
    } mon_t;

    mon_t q, d;

    logic scl_s, sda_s;
    assign scl_s = q.scl_sh[SYNC_STAGES-1];
    assign sda_s = q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        d.sda_sh = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;
        if (scl_s && sda_s) begin
            if (q.cnt < avail_cycles_i) begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.scl_sh <= '1;
            q.sda_sh <= '1;
            q.scl_p  <= 1'b1;
            q.sda_p  <= 1'b1;
            q.cnt    <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s && !q.scl_p;
    assign scl_fall_o = !scl_s && q.scl_p;
    assign start_o    = scl_s && q.scl_p && q.sda_p && !sda_s;
    assign stop_o     = scl_s && q.scl_p && !q.sda_p && sda_s;
    assign avail_o    = scl_s && sda_s && (q.cnt >= avail_cycles_i);

endmodule

// File: rtl/ibi_fsm.sv
module ibi_fsm
    import ibi_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              avail_i,
    input  logic [ADDR_W-1:0] dyn_addr_i,
    input  logic              req_i,
    input  logic [DATA_W-1:0] payload_i,
    input  logic              payload_en_i,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              lost_o,
    output logic              nacked_o
);

    localparam int HDR_LEN = ADDR_W + 1;
    localparam int MAX_LEN = (HDR_LEN > DATA_W) ? HDR_LEN : DATA_W;
    localparam int IDX_W   = $clog2(MAX_LEN);

    typedef struct packed {
        ibi_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic              oe;
        logic [DATA_W-1:0] pay;
        logic              pen;
        logic              free;
        logic              done;
        logic              lost;
        logic              nack;
    } fsm_t;

    fsm_t q, d;

    logic [HDR_LEN-1:0] hdr;
    assign hdr = {dyn_addr_i, 1'b1};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.lost = 1'b0;
        d.nack = 1'b0;

        if (stop_i || avail_i) d.free = 1'b1;
        if (start_i)           d.free = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                d.oe = 1'b0;
                if (req_i) begin
                    d.st  = ST_ARMED;
                    d.pay = payload_i;
                    d.pen = payload_en_i;
                end
            end
            ST_ARMED: begin
                d.oe = 1'b0;
                if (start_i && q.free) begin
                    d.st = ST_HDR_WAIT;
                end else if (avail_i) begin
                    d.st = ST_SELF_START;
                    d.oe = 1'b1;
                end
            end
            ST_HDR_WAIT, ST_SELF_START: begin
                if (stop_i) begin
                    d.st = ST_ARMED;
                    d.oe = 1'b0;
                end else if (scl_fall_i) begin
                    d.st  = ST_ADDR;
                    d.idx = IDX_W'(HDR_LEN - 1);
                    d.oe  = !hdr[HDR_LEN-1];
                end
            end
            ST_ADDR: begin
                if (stop_i) begin
                    d.st = ST_ARMED;
                    d.oe = 1'b0;
                end else if (scl_rise_i) begin
                    if (hdr[q.idx] && !sda_i) begin
                        d.st   = ST_BACKOFF;
                        d.oe   = 1'b0;
                        d.lost = 1'b1;
                    end else if (q.idx == '0) begin
                        d.st = ST_ACK;
                    end else begin
                        d.idx = q.idx - 1'b1;
                    end
                end else if (scl_fall_i) begin
                    d.oe = !hdr[q.idx];
                end
            end
            ST_ACK: begin
                if (stop_i) begin
                    d.st = ST_ARMED;
                    d.oe = 1'b0;
                end else if (scl_fall_i) begin
                    d.oe = 1'b0;
                end else if (scl_rise_i) begin
                    if (!sda_i) begin
                        if (q.pen) begin
                            d.st  = ST_DATA;
                            d.idx = IDX_W'(DATA_W - 1);
                        end else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.st   = ST_ARMED;
                        d.nack = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (stop_i) begin
                    d.st = ST_ARMED;
                    d.oe = 1'b0;
                end else if (scl_fall_i) begin
                    d.oe = !q.pay[q.idx];
                end else if (scl_rise_i) begin
                    if (q.idx == '0) d.st = ST_TAIL;
                    else             d.idx = q.idx - 1'b1;
                end
            end
            ST_TAIL: begin
                if (scl_fall_i || stop_i) begin
                    d.st   = ST_IDLE;
                    d.oe   = 1'b0;
                    d.done = 1'b1;
                end
            end
            ST_BACKOFF: begin
                d.oe = 1'b0;
                if (avail_i) d.st = ST_ARMED;
            end
            default: begin
                d.st = ST_IDLE;
                d.oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st   <= ST_IDLE;
            q.idx  <= '0;
            q.oe   <= 1'b0;
            q.pay  <= '0;
            q.pen  <= 1'b0;
            q.free <= 1'b0;
            q.done <= 1'b0;
            q.lost <= 1'b0;
            q.nack <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign busy_o   = (q.st != ST_IDLE);
    assign done_o   = q.done;
    assign lost_o   = q.lost;
    assign nacked_o = q.nack;

endmodule

// File: rtl/ibi_requester.sv
module ibi_requester #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] dyn_addr_i,
    input  logic [CNT_W-1:0]  avail_cycles_i,
    input  logic              req_i,
    input  logic [DATA_W-1:0] payload_i,
    input  logic              payload_en_i,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              lost_o,
    output logic              nacked_o
);

    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev, avail;

    ibi_bus_mon #(
        .SYNC_STAGES(SYNC_STAGES),
        .CNT_W      (CNT_W)
    ) mon_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .scl_i         (scl_i),
        .sda_i         (sda_i),
        .avail_cycles_i(avail_cycles_i),
        .sda_o         (sda_s),
        .scl_rise_o    (scl_rise),
        .scl_fall_o    (scl_fall),
        .start_o       (start_ev),
        .stop_o        (stop_ev),
        .avail_o       (avail)
    );

    ibi_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) fsm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .sda_i       (sda_s),
        .start_i     (start_ev),
        .stop_i      (stop_ev),
        .avail_i     (avail),
        .dyn_addr_i  (dyn_addr_i),
        .req_i       (req_i),
        .payload_i   (payload_i),
        .payload_en_i(payload_en_i),
        .sda_oe_o    (sda_oe_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .lost_o      (lost_o),
        .nacked_o    (nacked_o)
    );

endmodule

// File: rtl/ibi_requester_chk.sv
module ibi_requester_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sda_oe_o,
    input logic busy_o,
    input logic done_o,
    input logic lost_o,
    input logic nacked_o
);

    // R9
    status_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({done_o, lost_o, nacked_o}));

    // R3
    lost_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lost_o |-> !sda_oe_o);

    // R6
    backoff_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lost_o |=> !sda_oe_o);

    // R4
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R5
    nack_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nacked_o |-> busy_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !sda_oe_o);

endmodule

bind ibi_requester ibi_requester_chk chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sda_oe_o(sda_oe_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .lost_o  (lost_o),
    .nacked_o(nacked_o)
);

// File: tb/ibi_requester_tb.sv
module ibi_requester_tb_top;

    localparam int H  = 6;
    localparam int AV = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_c = 1'b1;
    logic       csda = 1'b0;
    logic       oth_oe = 1'b0;
    logic [6:0] addr = 7'h01;
    logic       req = 1'b0;
    logic [7:0] pay = 8'h00;
    logic       pen = 1'b0;
    logic       sda_oe, busy, done, lost, nacked;
    logic       line;

    int total = 0;
    int bad = 0;
    int n_done = 0;
    int n_lost = 0;
    int n_nack = 0;

    bit         oth_act = 1'b0;
    logic [7:0] oth_hdr = 8'h00;
    int         oth_idx = 0;

    assign line = csda & ~sda_oe & ~oth_oe;

    always #4 clk = ~clk;

    ibi_requester dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .scl_i         (scl_c),
        .sda_i         (line),
        .dyn_addr_i    (addr),
        .avail_cycles_i(8'(AV)),
        .req_i         (req),
        .payload_i     (pay),
        .payload_en_i  (pen),
        .sda_oe_o      (sda_oe),
        .busy_o        (busy),
        .done_o        (done),
        .lost_o        (lost),
        .nacked_o      (nacked)
    );

    always @(posedge clk) begin
        if (done)   n_done <= n_done + 1;
        if (lost)   n_lost <= n_lost + 1;
        if (nacked) n_nack <= n_nack + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string r, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic clk_bit(input logic v, output logic got);
        scl_c = 1'b0;
        tick(1);
        csda = v;
        if (oth_act && oth_idx < 8) oth_oe = ~oth_hdr[7-oth_idx];
        else                        oth_oe = 1'b0;
        tick(H - 1);
        scl_c = 1'b1;
        tick(H / 2);
        got = line;
        if (oth_act && oth_idx < 8) begin
            if (got != oth_hdr[7-oth_idx]) oth_act = 1'b0;
            oth_idx++;
        end
        tick(H - H / 2);
    endtask

    task automatic header(input logic ackv, output logic [7:0] hb);
        logic b;
        hb = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, b);
            hb = {hb[6:0], b};
        end
        clk_bit(ackv, b);
        oth_act = 1'b0;
        oth_oe  = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic b;
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, b);
            v = {v[6:0], b};
        end
    endtask

    task automatic do_start();
        scl_c = 1'b1;
        csda  = 1'b1;
        tick(H);
        csda = 1'b0;
        tick(H);
    endtask

    task automatic do_rstart();
        scl_c = 1'b0;
        tick(1);
        csda = 1'b1;
        tick(H);
        scl_c = 1'b1;
        tick(H);
        csda = 1'b0;
        tick(H);
    endtask

    task automatic do_stop();
        scl_c  = 1'b0;
        oth_oe = 1'b0;
        tick(1);
        csda = 1'b0;
        tick(H);
        scl_c = 1'b1;
        tick(H);
        csda = 1'b1;
        tick(H);
    endtask

    task automatic wait_self(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < AV + 80; k++) begin
            if (scl_c && !line) begin
                ok = 1'b1;
                break;
            end
            tick(1);
        end
        tick(H);
    endtask

    task automatic request(input logic [6:0] a, input logic [7:0] p, input logic e);
        addr = a;
        pay  = p;
        pen  = e;
        req  = 1'b1;
        tick(1);
        req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] hb, v;
        bit ok;
        int d0, l0, n0;

        tick(4);
        rst_n = 1'b1;
        tick(6);
        // R1: reset state
        chk("R1 oe", int'(sda_oe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 pulses", n_done + n_lost + n_nack, 0);
        csda = 1'b1;
        tick(H);

        // R8: request arrives mid-transaction, repeated START not joined
        do_start();
        header(1'b1, hb);
        chk("R8 first header", int'(hb), 8'hFF);
        request(7'h2A, 8'h00, 1'b0);
        chk("R2 busy after request", int'(busy), 1);
        do_rstart();
        header(1'b1, hb);
        chk("R8 repeated header untouched", int'(hb), 8'hFF);
        do_stop();
        // R7: self-generated start after idle window
        d0 = n_done;
        wait_self(ok);
        chk("R7 self start", int'(ok), 1);
        header(1'b0, hb);
        chk("R7 header", int'(hb), int'({7'h2A, 1'b1}));
        chk("R4 done no payload", n_done - d0, 1);
        do_stop();

        // address grid sweep: R2 R3 R4 R6 R7
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [6:0] a, o, mn;
                logic [7:0] p;
                logic       e;
                a  = 7'(1 + 17 * i);
                o  = 7'(8 + 15 * j);
                mn = (a < o) ? a : o;
                p  = {a, 1'b0} ^ {1'b1, o};
                e  = ((i + j) % 2) == 0;
                d0 = n_done;
                l0 = n_lost;
                n0 = n_nack;
                request(a, p, e);
                do_start();
                oth_act = 1'b1;
                oth_hdr = {o, 1'b1};
                oth_idx = 0;
                header(1'b0, hb);
                chk("R3 wired header", int'(hb), int'({mn, 1'b1}));
                if (a < o) begin
                    if (e) begin
                        read_byte(v);
                        chk("R4 payload", int'(v), int'(p));
                    end
                    do_stop();
                    chk("R4 done", n_done - d0, 1);
                    chk("R3 no loss", n_lost - l0, 0);
                    chk("R4 busy cleared", int'(busy), 0);
                end else begin
                    chk("R3 lost", n_lost - l0, 1);
                    chk("R3 still busy", int'(busy), 1);
                    do_stop();
                    do_start();
                    header(1'b1, hb);
                    chk("R6 no join before idle", int'(hb), 8'hFF);
                    do_stop();
                    wait_self(ok);
                    chk("R7 retry self start", int'(ok), 1);
                    header(1'b0, hb);
                    chk("R2 retry header", int'(hb), int'({a, 1'b1}));
                    if (e) begin
                        read_byte(v);
                        chk("R4 retry payload", int'(v), int'(p));
                    end
                    do_stop();
                    chk("R4 retry done", n_done - d0, 1);
                end
                chk("R9 nack count", n_nack - n0, 0);
            end
        end

        // R5: NACK then retry at next START
        for (int k = 0; k < 4; k++) begin
            logic [6:0] a;
            a  = 7'(5 + 31 * k);
            d0 = n_done;
            n0 = n_nack;
            request(a, 8'(8'hC3 ^ k), 1'b1);
            do_start();
            header(1'b1, hb);
            chk("R5 header", int'(hb), int'({a, 1'b1}));
            chk("R5 nacked", n_nack - n0, 1);
            chk("R5 still armed", int'(busy), 1);
            do_stop();
            do_start();
            header(1'b0, hb);
            chk("R5 rejoin header", int'(hb), int'({a, 1'b1}));
            read_byte(v);
            chk("R5 payload", int'(v), int'(8'hC3 ^ k));
            do_stop();
            chk("R5 done after retry", n_done - d0, 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule